// File: doc/BRIEF.md
# Serial GPIO Scan Engine

The block drives a chain of external shift registers over three wires (serial clock, serial data out, load strobe) and reads back a serial data-in line from the same chain. It scans up to 32 ports, each 1 to 4 bits wide. For every enabled port it shifts out one static output bit per bit index, taken from that port's configuration word. At the same time it samples the returning bit into a shadow copy. After the last bit it pulses the load strobe, and only then do the sampled bits become visible in the input data words.

A simple synchronous register port sets up the scan. It holds the port width, the serial clock divider, the port enable mask, the gap between repeated bursts, an auto-repeat flag, a single-shot trigger, and one configuration word per port. With auto-repeat set, bursts run back to back, separated by the programmed gap. With auto-repeat clear, setting the single-shot bit launches exactly one burst on the next serial clock boundary. The block clears the single-shot bit by itself when that burst ends.

Input data is stored transposed. There is one 32-bit word per bit index, and within a word the bit position is the port number.

Top module: `serial_gpio_scan`

## Requirements
- R1: After reset, every port configuration word, the control word, the mask and the input data words read 0, no burst runs, and the serial clock, data and load outputs are low.
- R2: Register map: address 0 is control, with bits 1:0 holding the port width as bit count minus one, bit 2 auto-repeat and bit 3 single-shot. Address 1 is the 12-bit divider, address 2 the 32-bit port enable mask and address 3 the 8-bit burst gap. Addresses 4 to 7 are the read-only input words for bit indices 0 to 3, and address 32+p is the 12-bit configuration word of port p. Written values read back one cycle after the read address is presented.
- R3: One serial clock period lasts max(2, divider) system clock cycles. The serial clock gives one high pulse per shifted bit and rises floor(period/2) cycles after the start of the bit slot.
- R4: A burst shifts only enabled ports, in ascending port order starting at port 0, and within each port bit indices 0 up to the width. The data bit for port p, bit b, is bit 3*b of that port's configuration word; bits 3*b+1 and 3*b+2 have no effect on the output.
- R5: After the last shifted bit, the load strobe is high for exactly one serial clock period, with the serial clock held low.
- R6: The data-in value sampled at the serial clock rise of slot (p,b) ends up in bit p of input word b. Positions not scanned in the last burst read 0.
- R7: The input data words change only at the end of a complete burst; a read during a burst returns the previous scan.
- R8: With auto-repeat set, bursts repeat. From the fall of the load strobe to the first serial clock rise of the next burst there are G*P + floor(P/2) system cycles, where G is the gap and P the period. Once auto-repeat is cleared, no further burst starts after the one in progress.
- R9: With auto-repeat clear, setting single-shot runs exactly one burst. The single-shot bit then reads 0, and no further burst follows.
- R10: While auto-repeat is set, the single-shot bit stays set until software writes it.
- R11: A burst with an empty enable mask produces only the load strobe, with no serial clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| sdin | input | 1 | Serial data returning from the shift-register chain |
| sclk | output | 1 | Serial clock to the chain |
| sdout | output | 1 | Serial data to the chain |
| sload | output | 1 | Load strobe after the last bit of a burst |

## Verification
The embedded assertions check, on every cycle, that the serial clock and the load strobe are never high together, and that the serial clock pulses only while bits are being shifted. They also check that divider ticks are never adjacent, that the input words hold still except on a burst commit, and that auto-repeat keeps the single-shot bit set. Only the bench scenarios can show the rest:
- the exact bit order and the source-bit selection across mask and width patterns;
- the transposed placement of sampled bits;
- the measured clock period, load length and burst gap;
- that a single shot runs once and clears itself;
- that a read during a burst still returns the previous scan.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_LOAD, SQ_GAP} sq_state_e;
  localparam int SRC_STRIDE = 3;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DIV   = 1;
  localparam int ADDR_MASK  = 2;
  localparam int ADDR_GAP   = 3;
  localparam int ADDR_INW   = 4;
endpackage

// File: rtl/sgpio_clkgen.sv
module sgpio_clkgen #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  output logic            tick,
  output logic            mid
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] dv;
  logic [DIVW-1:0] half;

  always_comb begin
    dv   = (div < DIVW'(2)) ? DIVW'(2) : div;
    half = dv >> 1;
    tick = (cnt >= dv - DIVW'(1));
    mid  = (cnt == half - DIVW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIVW'(1);
  end

  // R3: a serial period is never shorter than two system cycles
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R3: the rising point of the serial clock lies strictly inside a period
  a_r3_mid_inside: assert property (@(posedge clk) disable iff (rst)
    !(tick && mid));
endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIVW    = 12,
  parameter int GAPW    = 8,
  parameter int AW      = 6,
  parameter int DW      = 32,
  localparam int PW     = $clog2(NPORTS),
  localparam int BW     = $clog2(MAXBITS),
  localparam int CFGW   = SRC_STRIDE * MAXBITS,
  localparam int CFG_BASE = 1 << (AW - 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [DW-1:0]                   wr_data,
  input  logic [AW-1:0]                   rd_addr,
  output logic [DW-1:0]                   rd_data,
  input  logic                            commit,
  input  logic                            shot_done,
  input  logic [MAXBITS-1:0][NPORTS-1:0]  shadow,
  input  logic [PW-1:0]                   cur_port,
  input  logic [BW-1:0]                   cur_bit,
  output logic                            src_bit,
  output logic [BW-1:0]                   width,
  output logic                            auto_rep,
  output logic                            shot,
  output logic [DIVW-1:0]                 div,
  output logic [NPORTS-1:0]               mask,
  output logic [GAPW-1:0]                 gap
);
  logic [CFGW-1:0]                 cfg_mem [NPORTS];
  logic [MAXBITS-1:0][NPORTS-1:0]  in_words;
  logic [CFGW-1:0]                 cur_word;
  int                              wa;
  int                              ra;
  logic                            wr_ctrl;

  always_comb begin
    wa      = int'(wr_addr);
    ra      = int'(rd_addr);
    wr_ctrl = wr_en && (wa == ADDR_CTRL);
  end

  // source bit of the slot being shifted: lowest bit of the 3-bit field
  always_comb begin
    cur_word = cfg_mem[cur_port];
    src_bit  = 1'b0;
    for (int b = 0; b < MAXBITS; b++)
      if (cur_bit == BW'(b)) src_bit = cur_word[SRC_STRIDE*b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width    <= '0;
      auto_rep <= 1'b0;
      div      <= '0;
      mask     <= '0;
      gap      <= '0;
    end else if (wr_en) begin
      if (wa == ADDR_CTRL) begin
        width    <= wr_data[BW-1:0];
        auto_rep <= wr_data[BW];
      end
      if (wa == ADDR_DIV)  div  <= wr_data[DIVW-1:0];
      if (wa == ADDR_MASK) mask <= wr_data[NPORTS-1:0];
      if (wa == ADDR_GAP)  gap  <= wr_data[GAPW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         shot <= 1'b0;
    else if (wr_ctrl)                shot <= wr_data[BW+1];
    else if (shot_done && !auto_rep) shot <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORTS; i++) cfg_mem[i] <= '0;
    end else if (wr_en && wa >= CFG_BASE && wa < CFG_BASE + NPORTS) begin
      cfg_mem[PW'(wa - CFG_BASE)] <= wr_data[CFGW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         in_words <= '0;
    else if (commit) in_words <= shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (ra == ADDR_CTRL)      rd_data <= DW'({shot, auto_rep, width});
      else if (ra == ADDR_DIV)  rd_data <= DW'(div);
      else if (ra == ADDR_MASK) rd_data <= DW'(mask);
      else if (ra == ADDR_GAP)  rd_data <= DW'(gap);
      else if (ra >= ADDR_INW && ra < ADDR_INW + MAXBITS)
        rd_data <= DW'(in_words[BW'(ra - ADDR_INW)]);
      else if (ra >= CFG_BASE && ra < CFG_BASE + NPORTS)
        rd_data <= DW'(cfg_mem[PW'(ra - CFG_BASE)]);
    end
  end

  // R7: the visible scan changes only on a burst commit
  a_r7_inputs_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(in_words));
  // R10: auto-repeat keeps a pending single-shot request set
  a_r10_shot_kept: assert property (@(posedge clk) disable iff (rst)
    (shot && auto_rep && !wr_ctrl) |=> shot);
endmodule

// File: rtl/sgpio_seq.sv
module sgpio_seq
  import sgpio_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int GAPW    = 8,
  localparam int PW     = $clog2(NPORTS),
  localparam int BW     = $clog2(MAXBITS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic                            mid,
  input  logic [BW-1:0]                   width,
  input  logic                            auto_rep,
  input  logic                            shot,
  input  logic [NPORTS-1:0]               mask,
  input  logic [GAPW-1:0]                 gap,
  input  logic                            src_bit,
  input  logic                            sdin,
  output logic [PW-1:0]                   cur_port,
  output logic [BW-1:0]                   cur_bit,
  output logic [MAXBITS-1:0][NPORTS-1:0]  shadow,
  output logic                            commit,
  output logic                            shot_done,
  output logic                            sclk_q,
  output logic                            sdout_q,
  output logic                            sload_q
);
  sq_state_e      state;
  logic [GAPW-1:0] gcnt;
  logic [PW:0]     first_en;
  logic [PW:0]     next_en;
  logic            go_burst;

  // lowest enabled port at or above lo; MSB flags a hit
  function automatic logic [PW:0] find_from(input logic [NPORTS-1:0] m, input int lo);
    logic [PW:0] r;
    r = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (m[i] && i >= lo) r = {1'b1, PW'(i)};
    return r;
  endfunction

  always_comb begin
    first_en = find_from(mask, 0);
    next_en  = find_from(mask, int'(cur_port) + 1);
    go_burst = tick && (
      (state == SQ_IDLE && (auto_rep || shot)) ||
      (state == SQ_LOAD && auto_rep && gap == '0) ||
      (state == SQ_GAP  && auto_rep && gcnt <= GAPW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_port  <= '0;
      cur_bit   <= '0;
      gcnt      <= '0;
      shadow    <= '0;
      commit    <= 1'b0;
      shot_done <= 1'b0;
      sclk_q    <= 1'b0;
      sdout_q   <= 1'b0;
      sload_q   <= 1'b0;
    end else begin
      commit    <= 1'b0;
      shot_done <= 1'b0;
      sdout_q   <= (state == SQ_SHIFT) ? src_bit : 1'b0;
      if (state == SQ_SHIFT && mid) begin
        sclk_q                    <= 1'b1;
        shadow[cur_bit][cur_port] <= sdin;
      end
      if (tick) sclk_q <= 1'b0;
      if (go_burst) begin
        shadow   <= '0;
        cur_bit  <= '0;
        cur_port <= first_en[PW-1:0];
        state    <= first_en[PW] ? SQ_SHIFT : SQ_LOAD;
        sload_q  <= !first_en[PW];
        commit   <= !first_en[PW];
      end else if (tick) begin
        case (state)
          SQ_SHIFT: begin
            if (cur_bit < width) begin
              cur_bit <= cur_bit + BW'(1);
            end else if (next_en[PW]) begin
              cur_port <= next_en[PW-1:0];
              cur_bit  <= '0;
            end else begin
              state   <= SQ_LOAD;
              sload_q <= 1'b1;
              commit  <= 1'b1;
            end
          end
          SQ_LOAD: begin
            sload_q <= 1'b0;
            if (auto_rep) begin
              state <= SQ_GAP;
              gcnt  <= gap;
            end else begin
              state     <= SQ_IDLE;
              shot_done <= 1'b1;
            end
          end
          SQ_GAP: begin
            if (!auto_rep) state <= SQ_IDLE;
            else           gcnt  <= gcnt - GAPW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the load strobe never overlaps a serial clock pulse
  a_r5_load_clock_quiet: assert property (@(posedge clk) disable iff (rst)
    !(sclk_q && sload_q));
  // R4: serial clock pulses only while bits are being shifted
  a_r4_clock_only_shifting: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> state == SQ_SHIFT);
  // R9: completion of a single shot happens only as the load strobe ends
  a_r9_done_after_load: assert property (@(posedge clk) disable iff (rst)
    shot_done |-> $fell(sload_q));
endmodule

// File: rtl/serial_gpio_scan.sv
module serial_gpio_scan #(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIVW    = 12,
  parameter int GAPW    = 8,
  parameter int AW      = 6,
  parameter int DW      = 32,
  localparam int PW     = $clog2(NPORTS),
  localparam int BW     = $clog2(MAXBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sdin,
  output logic          sclk,
  output logic          sdout,
  output logic          sload
);
  logic                           tick, mid;
  logic [BW-1:0]                  width;
  logic                           auto_rep, shot;
  logic [DIVW-1:0]                div;
  logic [NPORTS-1:0]              mask;
  logic [GAPW-1:0]                gap;
  logic                           src_bit;
  logic [PW-1:0]                  cur_port;
  logic [BW-1:0]                  cur_bit;
  logic [MAXBITS-1:0][NPORTS-1:0] shadow;
  logic                           commit, shot_done;

  sgpio_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .div(div), .tick(tick), .mid(mid));

  sgpio_regs #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIVW(DIVW), .GAPW(GAPW), .AW(AW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit), .shot_done(shot_done),
    .shadow(shadow), .cur_port(cur_port), .cur_bit(cur_bit), .src_bit(src_bit),
    .width(width), .auto_rep(auto_rep), .shot(shot), .div(div), .mask(mask), .gap(gap));

  sgpio_seq #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .GAPW(GAPW)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .mid(mid), .width(width), .auto_rep(auto_rep),
    .shot(shot), .mask(mask), .gap(gap), .src_bit(src_bit), .sdin(sdin),
    .cur_port(cur_port), .cur_bit(cur_bit), .shadow(shadow), .commit(commit),
    .shot_done(shot_done), .sclk_q(sclk), .sdout_q(sdout), .sload_q(sload));
endmodule

// File: tb/sim_serial_gpio_scan.sv
module sim_serial_gpio_scan;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [5:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        sdin, sclk, sdout, sload;

  serial_gpio_scan u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sdin(sdin),
    .sclk(sclk), .sdout(sdout), .sload(sload));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  // behavioural model of the shift-register chain and the software view
  logic [11:0] b_cfg [32];
  logic [31:0] b_mask = 0;
  int          b_width = 0;
  logic        pat [128];
  int          ridx = 0;
  assign sdin = pat[ridx];

  logic        got [$];
  logic        last_got [$];
  int bursts = 0, load_rise = 0, load_len = 0, fall_cyc = 0, gap_meas = -1;
  int last_rise = -1, iv_min = 1 << 30, iv_max = 0, overlap = 0;
  bit gap_armed = 0, p_sclk = 0, p_sload = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sclk && sload) overlap++;
    if (sclk && !p_sclk) begin
      got.push_back(sdout);
      if (last_rise >= 0) begin
        if (cyc - last_rise < iv_min) iv_min = cyc - last_rise;
        if (cyc - last_rise > iv_max) iv_max = cyc - last_rise;
      end
      last_rise = cyc;
      if (gap_armed) begin gap_meas = cyc - fall_cyc; gap_armed = 0; end
      ridx++;
    end
    if (sload && !p_sload) begin
      bursts++; load_rise = cyc; last_got = got; got.delete();
    end
    if (!sload && p_sload) begin
      load_len = cyc - load_rise; fall_cyc = cyc; gap_armed = 1; ridx = 0; last_rise = -1;
    end
    p_sclk = sclk; p_sload = sload;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a >= 32) b_cfg[a-32] = d[11:0];
    if (a == 2) b_mask = d;
    if (a == 0) b_width = int'(d[1:0]);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_addr = 6'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_bursts(input int n);
    for (int i = 0; i < 6000 && bursts < n; i++) @(negedge clk);
  endtask

  task automatic reset_iv();
    iv_min = 1 << 30; iv_max = 0;
  endtask

  // expected serial stream and transposed input words from the model
  task automatic expect_scan(output logic [127:0] v, output int n, output logic [31:0] w [4]);
    n = 0; v = '0;
    for (int b = 0; b < 4; b++) w[b] = 0;
    for (int p = 0; p < 32; p++)
      if (b_mask[p])
        for (int b = 0; b <= b_width; b++) begin
          v[n] = b_cfg[p][3*b]; w[b][p] = pat[n]; n++;
        end
  endtask

  task automatic check_burst(input string tag);
    logic [127:0] ev, gv; int en; logic [31:0] ew [4]; logic [31:0] rv;
    expect_scan(ev, en, ew);
    gv = '0;
    foreach (last_got[i]) gv[i] = last_got[i];
    chk(last_got.size() == en, {tag, " R4 bit count"}, 128'(last_got.size()), 128'(en));
    chk(gv == ev, {tag, " R4 bit order/source"}, gv, ev);
    repeat (3) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      rd(4 + b, rv);
      chk(rv == ew[b], {tag, " R6 input word"}, 128'(rv), 128'(ew[b]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; int nb;
    for (int i = 0; i < 32; i++) b_cfg[i] = 0;
    for (int i = 0; i < 128; i++) pat[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(sclk == 0 && sdout == 0 && sload == 0, "R1 outputs low", {sclk, sdout, sload}, 0);
    rd(0, v);  chk(v == 0, "R1 control", v, 0);
    rd(35, v); chk(v == 0, "R1 port cfg", v, 0);
    rd(4, v);  chk(v == 0, "R1 input word", v, 0);
    repeat (50) @(negedge clk);
    chk(bursts == 0, "R1 no burst", bursts, 0);

    // R2 register readback
    wr(1, 32'h4); wr(2, 32'h25); wr(3, 32'h0);
    rd(1, v); chk(v == 32'h4, "R2 divider", v, 32'h4);
    rd(2, v); chk(v == 32'h25, "R2 mask", v, 32'h25);
    wr(32 + 5, 32'h7); rd(32 + 5, v); chk(v == 32'h7, "R2 cfg", v, 32'h7);

    // R4/R6/R9: ports 0,2,5 with 2 bits; port 5 upper field bits set but ignored
    wr(32 + 0, 32'h009); wr(32 + 2, 32'h008); wr(32 + 1, 32'h009);
    pat[0] = 1; pat[1] = 0; pat[2] = 1; pat[3] = 1; pat[4] = 0; pat[5] = 1;
    reset_iv();
    wr(0, 32'h09);
    wait_bursts(1);
    chk(bursts == 1, "R9 one burst", bursts, 1);
    check_burst("A");
    chk(iv_min == 4 && iv_max == 4, "R3 period 4", {iv_min, iv_max}, {32'd4, 32'd4});
    chk(load_len == 4, "R5 load length", load_len, 4);
    rd(0, v); chk(v == 32'h1, "R9 shot cleared", v, 32'h1);
    repeat (300) @(negedge clk);
    chk(bursts == 1, "R9 no repeat", bursts, 1);

    // R7: read during a burst returns the previous scan
    for (int i = 0; i < 6; i++) pat[i] = ~pat[i];
    wr(0, 32'h09);
    for (int i = 0; i < 2000 && got.size() == 0; i++) @(negedge clk);
    rd(4, v); chk(v == 32'h05, "R7 old scan during burst", v, 32'h05);
    wait_bursts(2);
    check_burst("B");

    // R8/R10: auto-repeat with gap 3 and a pending shot
    wr(3, 32'h3);
    gap_meas = -1;
    nb = bursts;
    wr(0, 32'h0D);
    wait_bursts(nb + 3);
    chk(gap_meas == 14, "R8 burst gap", gap_meas, 14);
    rd(0, v); chk(v == 32'h0D, "R10 shot held", v, 32'h0D);
    wr(0, 32'h01);
    repeat (200) @(negedge clk);
    nb = bursts;
    repeat (400) @(negedge clk);
    chk(bursts == nb, "R8 auto stops", bursts, nb);

    // R3/R4 boundary: divider 0 clamps to 2, ports 0 and 31, 4 bits
    wr(1, 32'h0); wr(2, 32'h8000_0001);
    wr(32 + 31, 32'h249); wr(32 + 0, 32'h041);
    for (int i = 0; i < 8; i++) pat[i] = i[0];
    reset_iv();
    nb = bursts;
    wr(0, 32'h0B);
    wait_bursts(nb + 1);
    check_burst("C");
    chk(iv_min == 2 && iv_max == 2, "R3 clamped period", {iv_min, iv_max}, {32'd2, 32'd2});

    // R11 empty mask
    wr(2, 32'h0);
    nb = bursts;
    wr(0, 32'h08);
    wait_bursts(nb + 1);
    chk(bursts == nb + 1 && last_got.size() == 0, "R11 load only", last_got.size(), 0);
    repeat (3) @(negedge clk);
    rd(7, v); chk(v == 0, "R11 R6 words cleared", v, 0);

    chk(overlap == 0, "R5 clock low during load", overlap, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule